// File: doc/BRIEF.md
# Slow-Bus Stall Sequencer

This block sits between a fast 6502-class processor and a slow host bus that runs near 1 MHz. The host bus is time-shared: the video chip owns one half of every host cycle, and the processor owns the half in which the host phase-2 signal (S02) is high. A region decoder outside this block raises a request whenever the processor addresses slow memory or I/O. On such a request the sequencer pulls the processor's RDY input low and inhibits the fast RAM and ROM chip selects. It then lets any CPU half-cycle that is already under way go by. It waits for a fresh S02 rising edge and drives the captured address, R/W and, on writes, the data onto the host bus for a fixed window of fast-clock ticks.

When the window closes, RDY is released. A read returns the host data that was latched on the final tick of the window. A write leaves its address and data on the host bus until the next S02 rising edge, so slow devices see a full host cycle. Between accesses the host bus performs harmless reads of the last address used. The data drivers are switched off and R/W stays at read.

Top module: `slow_bus_stall_seq`

## Requirements
- R1: During and directly after reset, `cpu_rdy` is 1, `fast_cs_inhibit` is 0, `host_rnw` is 1, `host_wdata_oe` is 0 and `host_addr` is 0.
- R2: In the same cycle that `cpu_slow_req` is raised while the block is idle, `cpu_rdy` goes to 0 and `fast_cs_inhibit` goes to 1.
- R3: The host bus is not driven with a new access until a rising edge of `host_s02` that follows the request. An S02-high phase already in progress when the request arrives is not used. The edge takes effect after the synchronizer: the first driven cycle is SYNC_STAGES+1 clock cycles after the pin rises.
- R4: The access window lasts exactly WIN fast-clock cycles. Throughout it, `host_addr` holds the captured address and `host_rnw` holds the captured direction (1 = read, 0 = write). `host_wdata_oe` is 1 only for writes, and then `host_wdata` carries the captured data. `cpu_rdy` stays 0 for the whole window.
- R5: In the cycle after the window, `cpu_rdy` is 1. For a read, `cpu_rdata` equals the value on `host_rdata` in the last window cycle.
- R6: After a read, the host bus keeps reading the same address (`host_rnw`=1, `host_wdata_oe`=0) on later host cycles until a new access starts.
- R7: After a write, `host_addr`, `host_wdata`, `host_rnw`=0 and `host_wdata_oe`=1 persist until the next synchronized S02 rising edge. Then the bus returns to reading that address.
- R8: When no access is in its window or write tail, `host_rnw` is 1 and `host_wdata_oe` is 0. While idle with no request, `cpu_rdy` is 1 and `fast_cs_inhibit` is 0.
- R9: The completion cycle after a window always lasts one cycle, and a request held high during it does not extend it. A request still present in the following cycle is accepted as a new access, and `cpu_rdy` drops.
- R10: If a new request waits during a write tail, the S02 rising edge that ends the tail also starts the new window, with no idle cycle between them.
- R11: WIN equals the ceiling of WINDOW_PS divided by FAST_PERIOD_PS. This gives 7 for the defaults of 450000 ps and 69841 ps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | ADDR_W | Fast CPU address |
| cpu_wdata | input | DATA_W | Fast CPU write data |
| cpu_rnw | input | 1 | Fast CPU direction, 1 = read |
| cpu_slow_req | input | 1 | Decoded slow-region access request |
| cpu_rdy | output | 1 | Ready to the fast CPU, 0 = stall |
| cpu_rdata | output | DATA_W | Data latched from the host bus on reads |
| fast_cs_inhibit | output | 1 | 1 = block all fast RAM/ROM chip selects |
| host_s02 | input | 1 | Host phase-2 clock, asynchronous |
| host_addr | output | ADDR_W | Host bus address |
| host_wdata | output | DATA_W | Host bus write data |
| host_wdata_oe | output | 1 | Enable of the host data drivers |
| host_rnw | output | 1 | Host bus direction, 1 = read |
| host_rdata | input | DATA_W | Host bus read data |

## Verification
Two functions can fall in the same cycle. The end of a write's tail and the start of the next access's window both happen on one synchronized S02 rising edge. The bench provokes this by completing a write and then raising a read request while the tail is still on the bus, before lifting S02. It judges the result by sampling the host bus SYNC_STAGES cycles after the S02 edge, where the write must still be present, and one cycle later, where the read address must already be driven.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2,
    ST_DONE  = 2'd3
  } sbs_state_e;

  // Ceiling division used to turn the host window into fast-clock ticks.
  function automatic int sbs_ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Window length, never below one tick.
  function automatic int sbs_win_ticks(input int window_ps, input int period_ps);
    int t;
    t = sbs_ceil_div(window_ps, period_ps);
    return (t < 1) ? 1 : t;
  endfunction

endpackage

// File: rtl/sbs_phase_sync.sv
module sbs_phase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s02_async,
  output logic s02_sync,
  output logic s02_rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= s02_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign s02_sync = chain[STAGES-1];
  assign s02_rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/sbs_window_timer.sv
module sbs_window_timer #(
  parameter int WIN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);

  localparam int CW = (WIN < 2) ? 1 : $clog2(WIN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      remain <= CW'(WIN - 1);
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign last = active && (remain == '0);

endmodule

// File: rtl/sbs_host_mux.sv
module sbs_host_mux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              win_active,
  input  logic              tail_active,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_wdata,
  input  logic              cap_rnw,
  input  logic [ADDR_W-1:0] tail_addr,
  input  logic [DATA_W-1:0] tail_wdata,
  input  logic [ADDR_W-1:0] dummy_addr,
  output logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_wdata,
  output logic              host_wdata_oe,
  output logic              host_rnw
);

  always_comb begin
    if (win_active) begin
      host_addr     = cap_addr;
      host_rnw      = cap_rnw;
      host_wdata_oe = ~cap_rnw;
      host_wdata    = cap_rnw ? '0 : cap_wdata;
    end else if (tail_active) begin
      host_addr     = tail_addr;
      host_rnw      = 1'b0;
      host_wdata_oe = 1'b1;
      host_wdata    = tail_wdata;
    end else begin
      host_addr     = dummy_addr;
      host_rnw      = 1'b1;
      host_wdata_oe = 1'b0;
      host_wdata    = '0;
    end
  end

endmodule

// File: rtl/slow_bus_stall_seq.sv
module slow_bus_stall_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 8,
  parameter int FAST_PERIOD_PS = 69841,
  parameter int WINDOW_PS      = 450000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rnw,
  input  logic              cpu_slow_req,
  output logic              cpu_rdy,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              fast_cs_inhibit,
  input  logic              host_s02,
  output logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_wdata,
  output logic              host_wdata_oe,
  output logic              host_rnw,
  input  logic [DATA_W-1:0] host_rdata
);

  localparam int WIN = sbs_win_ticks(WINDOW_PS, FAST_PERIOD_PS);

  sbs_state_e state, state_nx;

  // Named internal events
  logic s02_sync;
  logic s02_rise;
  logic accept;
  logic win_start;
  logic win_active;
  logic win_last;
  logic tail_active;
  logic tail_set;
  logic tail_clr;

  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic              cap_rnw;
  logic [ADDR_W-1:0] tail_addr;
  logic [DATA_W-1:0] tail_wdata;
  logic [ADDR_W-1:0] dummy_addr;
  logic [DATA_W-1:0] rdata_q;

  sbs_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .s02_async (host_s02),
    .s02_sync  (s02_sync),
    .s02_rise  (s02_rise)
  );

  sbs_window_timer #(.WIN(WIN)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (win_start),
    .active (win_active),
    .last   (win_last)
  );

  assign accept    = (state == ST_IDLE) && cpu_slow_req;
  assign win_start = (state == ST_WAIT) && s02_rise;
  assign tail_set  = win_last && !cap_rnw;
  assign tail_clr  = tail_active && s02_rise;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept)    state_nx = ST_WAIT;
      ST_WAIT:  if (win_start) state_nx = ST_DRIVE;
      ST_DRIVE: if (win_last)  state_nx = ST_DONE;
      ST_DONE:                 state_nx = ST_IDLE;
      default:                 state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // Access capture on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_wdata <= '0;
      cap_rnw   <= 1'b1;
    end else if (accept) begin
      cap_addr  <= cpu_addr;
      cap_wdata <= cpu_wdata;
      cap_rnw   <= cpu_rnw;
    end
  end

  // End-of-window bookkeeping: read data, idle address, write tail
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      dummy_addr <= '0;
      tail_addr  <= '0;
      tail_wdata <= '0;
    end else if (win_last) begin
      dummy_addr <= cap_addr;
      if (cap_rnw) begin
        rdata_q <= host_rdata;
      end else begin
        tail_addr  <= cap_addr;
        tail_wdata <= cap_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tail_active <= 1'b0;
    else if (tail_set) tail_active <= 1'b1;
    else if (tail_clr) tail_active <= 1'b0;
  end

  sbs_host_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .win_active    (win_active),
    .tail_active   (tail_active),
    .cap_addr      (cap_addr),
    .cap_wdata     (cap_wdata),
    .cap_rnw       (cap_rnw),
    .tail_addr     (tail_addr),
    .tail_wdata    (tail_wdata),
    .dummy_addr    (dummy_addr),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_wdata_oe (host_wdata_oe),
    .host_rnw      (host_rnw)
  );

  always_comb begin
    cpu_rdy         = ((state == ST_IDLE) && !cpu_slow_req) || (state == ST_DONE);
    fast_cs_inhibit = !((state == ST_IDLE) && !cpu_slow_req);
  end

  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/sbs_stall_seq_chk.sv
module sbs_stall_seq_chk #(
  parameter int WIN    = 7,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rdy,
  input logic              fast_cs_inhibit,
  input logic              win_active,
  input logic              tail_active,
  input logic              s02_rise,
  input logic              host_rnw,
  input logic              host_wdata_oe,
  input logic [ADDR_W-1:0] host_addr
);

  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_cnt <= 0;
    else if (win_active) run_cnt <= run_cnt + 1;
    else                 run_cnt <= 0;
  end

  assert_stall_inhibits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdy |-> fast_cs_inhibit);

  assert_start_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_active) |-> $past(s02_rise));

  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_active) |-> (run_cnt == WIN));

  assert_stall_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> !cpu_rdy);

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_active && $past(win_active)) |-> $stable(host_addr));

  assert_tail_ends_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tail_active) |-> $past(s02_rise));

  assert_idle_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_active && !tail_active) |-> (host_rnw && !host_wdata_oe));

endmodule

bind slow_bus_stall_seq sbs_stall_seq_chk #(.WIN(WIN), .ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_rdy         (cpu_rdy),
  .fast_cs_inhibit (fast_cs_inhibit),
  .win_active      (win_active),
  .tail_active     (tail_active),
  .s02_rise        (s02_rise),
  .host_rnw        (host_rnw),
  .host_wdata_oe   (host_wdata_oe),
  .host_addr       (host_addr)
);

// File: tb/tb_slow_bus_stall_seq.sv
`timescale 1ns/1ps
module tb_slow_bus_stall_seq;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PER_PS = 69841;
  localparam int WND_PS = 450000;
  localparam int SYNC = 2;
  localparam int LAT = SYNC + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_rnw = 1'b1;
  logic          cpu_slow_req = 1'b0;
  logic          cpu_rdy;
  logic [DW-1:0] cpu_rdata;
  logic          fast_cs_inhibit;
  logic          host_s02 = 1'b0;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic          host_wdata_oe;
  logic          host_rnw;
  logic [DW-1:0] host_rdata = '0;

  int errors = 0;
  int checks = 0;
  int exp_win;

  always #4 clk = ~clk;

  slow_bus_stall_seq #(
    .ADDR_W(AW), .DATA_W(DW), .FAST_PERIOD_PS(PER_PS),
    .WINDOW_PS(WND_PS), .SYNC_STAGES(SYNC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .cpu_slow_req(cpu_slow_req), .cpu_rdy(cpu_rdy),
    .cpu_rdata(cpu_rdata), .fast_cs_inhibit(fast_cs_inhibit),
    .host_s02(host_s02), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wdata_oe(host_wdata_oe), .host_rnw(host_rnw), .host_rdata(host_rdata)
  );

  // rows: {rnw, s02_high_at_request, addr[15:0], wdata[7:0], rdata[7:0]}
  localparam logic [33:0] VEC [6] = '{
    {1'b1, 1'b0, 16'h9110, 8'h00, 8'h5A},
    {1'b0, 1'b0, 16'h9004, 8'hC3, 8'h00},
    {1'b1, 1'b1, 16'h1E00, 8'h00, 8'hA5},
    {1'b0, 1'b1, 16'h1234, 8'h3C, 8'h00},
    {1'b1, 1'b0, 16'h9400, 8'h00, 8'hFF},
    {1'b0, 1'b0, 16'h9120, 8'h01, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Runs one access up to and including the completion-cycle sample.
  task automatic access(input bit rnw, input bit pre_high, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    int early, first, cnt, rdy_bad;
    bit drv;
    host_s02 = pre_high;
    repeat (4) @(negedge clk);
    cpu_addr = addr; cpu_wdata = wd; cpu_rnw = rnw; cpu_slow_req = 1'b1;
    #1;
    chk(!cpu_rdy && fast_cs_inhibit, "R2 stall on request", {cpu_rdy, fast_cs_inhibit}, 2'b01);
    early = 0;
    repeat (5) begin
      @(negedge clk);
      if (host_addr == addr) early++;
    end
    if (pre_high) begin
      host_s02 = 1'b0;
      repeat (4) begin
        @(negedge clk);
        if (host_addr == addr) early++;
      end
    end
    chk(early == 0, "R3 no drive before next S02 rise", early, 0);
    @(negedge clk);
    host_s02 = 1'b1;
    host_rdata = rd;
    first = 0; cnt = 0; rdy_bad = 0;
    for (int k = 1; k <= LAT + exp_win - 1; k++) begin
      @(negedge clk);
      drv = (host_addr == addr) && (host_rnw == rnw) && (host_wdata_oe == !rnw) &&
            (rnw || host_wdata == wd);
      if (drv) begin
        cnt++;
        if (first == 0) first = k;
      end
      if (cpu_rdy) rdy_bad++;
    end
    chk(first == LAT, "R3 window starts after sync latency", first, LAT);
    chk(cnt == exp_win, "R4 window length", cnt, exp_win);
    chk(rdy_bad == 0, "R4 rdy low through window", rdy_bad, 0);
    @(negedge clk);
    chk(cpu_rdy == 1'b1, "R5 rdy released after window", cpu_rdy, 1);
    if (rnw) chk(cpu_rdata == rd, "R5 read data latched", cpu_rdata, rd);
  endtask

  initial begin
    int n;
    n = 0;
    while (n * PER_PS < WND_PS) n++;
    exp_win = (n < 1) ? 1 : n;

    repeat (3) @(negedge clk);
    chk(cpu_rdy && !fast_cs_inhibit && host_rnw && !host_wdata_oe && host_addr == 0,
        "R1 reset state", {cpu_rdy, fast_cs_inhibit, host_rnw, host_wdata_oe}, 4'b1010);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cpu_rdy && !fast_cs_inhibit && host_rnw && !host_wdata_oe && host_addr == 0,
        "R1 state after reset", {cpu_rdy, fast_cs_inhibit, host_rnw, host_wdata_oe}, 4'b1010);
    chk(exp_win == 7, "R11 default window ticks", exp_win, 7);

    for (int i = 0; i < 6; i++) begin
      logic [33:0] v;
      v = VEC[i];
      access(v[33], v[32], v[31:16], v[15:8], v[7:0]);
      cpu_slow_req = 1'b0;
      @(negedge clk);
      chk(cpu_rdy && !fast_cs_inhibit, "R8 idle after access", {cpu_rdy, fast_cs_inhibit}, 2'b10);
      if (v[33]) begin
        chk(host_addr == v[31:16] && host_rnw && !host_wdata_oe, "R6 dummy read same address",
            host_addr, v[31:16]);
        host_s02 = 1'b0;
        repeat (3) @(negedge clk);
        host_s02 = 1'b1;
        repeat (LAT + 1) @(negedge clk);
        chk(host_addr == v[31:16] && host_rnw && !host_wdata_oe, "R6 dummy read on later cycle",
            host_addr, v[31:16]);
      end else begin
        chk(host_addr == v[31:16] && !host_rnw && host_wdata_oe && host_wdata == v[15:8],
            "R7 write tail held", {host_rnw, host_wdata_oe, host_wdata}, {2'b01, v[15:8]});
        host_s02 = 1'b0;
        repeat (3) @(negedge clk);
        host_s02 = 1'b1;
        repeat (LAT - 1) @(negedge clk);
        chk(!host_rnw && host_wdata_oe, "R7 tail until edge", {host_rnw, host_wdata_oe}, 2'b01);
        @(negedge clk);
        chk(host_rnw && !host_wdata_oe && host_addr == v[31:16], "R7 tail released to read",
            {host_rnw, host_wdata_oe}, 2'b10);
      end
      host_s02 = 1'b0;
    end

    // R9: request held through completion cycle
    access(1'b1, 1'b0, 16'h9500, 8'h00, 8'h66);
    @(negedge clk);
    chk(!cpu_rdy && fast_cs_inhibit, "R9 held request accepted anew", {cpu_rdy, fast_cs_inhibit}, 2'b01);
    host_s02 = 1'b0;
    repeat (3) @(negedge clk);
    host_s02 = 1'b1;
    begin
      int w;
      w = 0;
      while (!cpu_rdy && w < 40) begin
        @(negedge clk);
        w++;
      end
      chk(w == LAT + exp_win, "R9 second access completes", w, LAT + exp_win);
    end
    cpu_slow_req = 1'b0;
    host_s02 = 1'b0;
    repeat (3) @(negedge clk);

    // R10: new read request waiting during a write tail
    access(1'b0, 1'b0, 16'h9130, 8'h77, 8'h00);
    cpu_slow_req = 1'b0;
    host_s02 = 1'b0;
    repeat (3) @(negedge clk);
    cpu_addr = 16'h9140; cpu_rnw = 1'b1; cpu_slow_req = 1'b1;
    @(negedge clk);
    host_s02 = 1'b1;
    host_rdata = 8'h3E;
    repeat (LAT - 1) @(negedge clk);
    chk(host_addr == 16'h9130 && !host_rnw && host_wdata_oe, "R10 tail present before edge",
        host_addr, 16'h9130);
    @(negedge clk);
    chk(host_addr == 16'h9140 && host_rnw && !host_wdata_oe, "R10 new window on same edge",
        host_addr, 16'h9140);
    repeat (exp_win) @(negedge clk);
    chk(cpu_rdy && cpu_rdata == 8'h3E, "R10 overlapped read completes", cpu_rdata, 8'h3E);
    cpu_slow_req = 1'b0;
    host_s02 = 1'b0;
    repeat (2) @(negedge clk);

    finish_run();
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule